// File: doc/BRIEF.md
# Rational Fractional-N Divide Modulator

This block sits beside the feedback divider of a fractional-N synthesizer. On every reference clock it produces the integer divide value for the next feedback cycle. That value is a programmed integer part plus a small signed offset taken from a cascade of up to three accumulators. The time average of these values equals the programmed divide ratio.

The fraction can be read in two ways. In binary mode the 28-bit fraction word counts in units of 2^-28. Rational mode is selected by a rational enable together with a nonzero 16-bit modulus. In that mode the accumulators wrap at the modulus, and the average ratio is exactly the integer part plus a 16-bit numerator divided by the modulus. The low six modulus bits are not a separate input: they are taken from the six least significant fraction bits, which carry no fraction weight in rational mode. A signed dither word may be added to the binary fraction on every update.

Configuration is captured only on a load strobe. That strobe also clears all accumulator state. Illegal settings raise an error flag, and the divide output is then held at zero.

Top module: `frac_mash_div`

## Requirements
- R1: While reset is high and after it is released, `div_out` is 0 and `err` is 0 until the first load.
- R2: A load captures every configuration input and clears the accumulators. `div_out` is 0 in the cycle after the load edge. Configuration inputs that change without a load have no effect.
- R3: In binary mode (modulus zero, or `rat_en` low), each update adds `frac_in` as a fraction of 2^28. With order 1, the sum of `div_out` over the first L updates is L*int + floor(L*frac/2^28).
- R4: In rational mode the modulus is {`mod_hi_in`, `frac_in[5:0]`} and the numerator is `frac_in[24:9]`. With order 1, the sum over L updates, where L is a multiple of the modulus, is exactly L*int + L*num/modulus.
- R5: Orders 2 and 3 use the cascaded error-cancelling sum, and any order of 3 or above acts as 3. Over L updates (a multiple of the fraction period), the summed `div_out` lies between (exact total − 1) and (exact total + 2).
- R6: Order 0 runs no modulation, so `div_out` equals the integer part on every update.
- R7: In rational mode a numerator above the modulus sets `err` at the load and forces `div_out` to 0. A numerator equal to the modulus is legal.
- R8: An integer part below 23 sets `err` at the load. Any later legal load clears it.
- R9: In binary mode the signed `dither_in` is shifted left by 12 and added to the fraction on every update. The sum is clamped to the range 0 to 2^28−1. A dither that alternates between +d and −d leaves the average unchanged. In rational mode dither is ignored.
- R10: `div_out` minus the integer part stays in [0,1] for order 1, in [−1,2] for order 2 and in [−3,4] for order 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one update per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Captures configuration and clears accumulators |
| int_in | input | 8 | Integer part of the divide ratio |
| frac_in | input | 28 | Binary fraction, or numerator [24:9] and modulus low bits [5:0] |
| mod_hi_in | input | 10 | Modulus bits [15:6] |
| rat_en | input | 1 | Rational mode enable (needs a nonzero modulus) |
| order_in | input | 3 | Modulator order, 0 = none, 3 or more = third order |
| dither_in | input | 16 | Signed dither, sampled live on each update |
| div_out | output | 9 | Instantaneous integer divide value |
| err | output | 1 | Illegal configuration flag |

## Verification
The assertions check the per-cycle behaviour on every cycle: the offset window for each order, the zero output while in error, the zeroing after a load, a constant output at order 0, and the first accumulator staying below the modulus. Exactness of the ratio cannot be seen in one cycle. The bench shows it by summing the output over whole modulus periods in binary, rational, dithered and clamped cases. It also checks that the error settings and unloaded input changes behave as required.

// File: rtl/frac_mash_div.sv
module frac_mash_div #(
  parameter int IW      = 8,
  parameter int FW      = 28,
  parameter int MW      = 16,
  parameter int MLOW    = 6,
  parameter int NUM_LSB = 9,
  parameter int DW      = 16,
  parameter int DSH     = 12,
  parameter int MIN_INT = 23,
  parameter int OW      = IW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [IW-1:0]        int_in,
  input  logic [FW-1:0]        frac_in,
  input  logic [MW-MLOW-1:0]   mod_hi_in,
  input  logic                 rat_en,
  input  logic [2:0]           order_in,
  input  logic signed [DW-1:0] dither_in,
  output logic [OW-1:0]        div_out,
  output logic                 err
);
  localparam int AW = FW + 1;
  localparam logic [AW-1:0] BIN_LIM = AW'(1) << FW;

  logic [IW-1:0] int_q;
  logic [FW-1:0] frac_q;
  logic [MW-1:0] mod_q;
  logic          rat_q;
  logic [1:0]    ord_q;

  logic [MW-1:0] mod_w, num_w;
  logic          rat_w, bad_w;
  logic [1:0]    ord_w;

  assign mod_w = {mod_hi_in, frac_in[MLOW-1:0]};
  assign num_w = frac_in[NUM_LSB+MW-1:NUM_LSB];
  assign rat_w = rat_en && (mod_w != '0);
  assign ord_w = (order_in >= 3'd3) ? 2'd3 : order_in[1:0];
  assign bad_w = (int_in < IW'(MIN_INT)) || (rat_w && (num_w > mod_w));

  logic signed [FW+1:0] dext, dsum;
  logic [AW-1:0] x, lim;

  assign dext = (FW+2)'(dither_in) <<< DSH;
  assign dsum = $signed({2'b00, frac_q}) + dext;
  assign lim  = rat_q ? AW'(mod_q) : BIN_LIM;

  always_comb begin
    if (rat_q)         x = AW'(frac_q[NUM_LSB+MW-1:NUM_LSB]);
    else if (dsum[FW+1]) x = '0;
    else if (dsum[FW])   x = BIN_LIM - AW'(1);
    else               x = AW'(dsum[FW-1:0]);
  end

  logic [AW-1:0] acc_q [3];
  logic [AW-1:0] acc_d [3];
  logic [AW-1:0] feed, sum_s;
  logic [2:0]    cy;
  logic          c2d, c3d, c3dd;

  always_comb begin
    feed = x;
    for (int k = 0; k < 3; k++) begin
      sum_s    = acc_q[k] + feed;
      cy[k]    = sum_s >= lim;
      acc_d[k] = cy[k] ? sum_s - lim : sum_s;
      feed     = acc_d[k];
    end
  end

  logic signed [3:0] off;

  always_comb begin
    off = $signed({3'b000, cy[0]});
    if (ord_q >= 2'd2)
      off = off + $signed({3'b000, cy[1]}) - $signed({3'b000, c2d});
    if (ord_q == 2'd3)
      off = off + $signed({3'b000, cy[2]}) - $signed({2'b00, c3d, 1'b0})
                + $signed({3'b000, c3dd});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q   <= '0;
      frac_q  <= '0;
      mod_q   <= '0;
      rat_q   <= 1'b0;
      ord_q   <= '0;
      err     <= 1'b0;
      div_out <= '0;
      c2d     <= 1'b0;
      c3d     <= 1'b0;
      c3dd    <= 1'b0;
      for (int k = 0; k < 3; k++) acc_q[k] <= '0;
    end else if (load) begin
      int_q   <= int_in;
      frac_q  <= frac_in;
      mod_q   <= mod_w;
      rat_q   <= rat_w;
      ord_q   <= ord_w;
      err     <= bad_w;
      div_out <= '0;
      c2d     <= 1'b0;
      c3d     <= 1'b0;
      c3dd    <= 1'b0;
      for (int k = 0; k < 3; k++) acc_q[k] <= '0;
    end else if (err) begin
      div_out <= '0;
    end else if (ord_q == 2'd0) begin
      div_out <= OW'(int_q);
    end else begin
      for (int k = 0; k < 3; k++) acc_q[k] <= acc_d[k];
      c2d     <= cy[1];
      c3d     <= cy[2];
      c3dd    <= c3d;
      div_out <= OW'(int_q) + OW'(off);
    end
  end
endmodule

// File: rtl/frac_mash_div_chk.sv
module frac_mash_div_chk #(
  parameter int IW      = 8,
  parameter int MW      = 16,
  parameter int AW      = 29,
  parameter int OW      = 9,
  parameter int MIN_INT = 23
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic          err,
  input logic [OW-1:0] div_out,
  input logic [IW-1:0] int_q,
  input logic [1:0]    ord_q,
  input logic          rat_q,
  input logic [MW-1:0] mod_q,
  input logic [AW-1:0] acc0
);
  assert_load_zero_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (div_out == '0));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> (div_out == '0));

  assert_min_int_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (err || (int_q >= IW'(MIN_INT))));

  assert_order0_flat_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !err && ord_q == 2'd0) |=> (div_out == OW'(int_q)));

  assert_order1_window_R10: assert property (@(posedge clk) disable iff (rst)
    (!load && !err && ord_q == 2'd1) |=>
      (int'(div_out) == int'(int_q) || int'(div_out) == int'(int_q) + 1));

  assert_order3_window_R10: assert property (@(posedge clk) disable iff (rst)
    (!load && !err && ord_q != 2'd0) |=>
      ((int'(div_out) + 3 >= int'(int_q)) && (int'(div_out) <= int'(int_q) + 4)));

  assert_residue_below_mod_R4: assert property (@(posedge clk) disable iff (rst)
    rat_q |-> (acc0 < AW'(mod_q)));
endmodule

bind frac_mash_div frac_mash_div_chk #(
  .IW(IW), .MW(MW), .AW(AW), .OW(OW), .MIN_INT(MIN_INT)
) u_chk (
  .clk(clk), .rst(rst), .load(load), .err(err), .div_out(div_out),
  .int_q(int_q), .ord_q(ord_q), .rat_q(rat_q), .mod_q(mod_q), .acc0(acc_q[0])
);

// File: tb/frac_mash_div_test.sv
module frac_mash_div_test;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               load = 1'b0;
  logic [7:0]         int_in = '0;
  logic [27:0]        frac_in = '0;
  logic [9:0]         mod_hi_in = '0;
  logic               rat_en = 1'b0;
  logic [2:0]         order_in = '0;
  logic signed [15:0] dither_in = '0;
  logic [8:0]         div_out;
  logic               err;

  frac_mash_div uut (
    .clk(clk), .rst(rst), .load(load), .int_in(int_in), .frac_in(frac_in),
    .mod_hi_in(mod_hi_in), .rat_en(rat_en), .order_in(order_in),
    .dither_in(dither_in), .div_out(div_out), .err(err)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0]  ii;
    logic [27:0] fr;
    logic [9:0]  mh;
    logic        rat;
    logic [2:0]  ord;
    logic [15:0] di;
    int          len;
    int          lo;
    int          hi;
    int          req;
  } vec_t;

  // rational fraction word = (numerator << 9) | modulus[5:0]; mod_hi = modulus >> 6
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'd40,  28'h8000000, 10'd0,  1'b1, 3'd1, 16'h0000, 16,   648,    648,    3}, // R3 half, modulus zero
    '{8'd50,  28'h4000000, 10'd5,  1'b0, 3'd1, 16'h0000, 32,   1608,   1608,   3}, // R3 rational off
    '{8'd255, 28'h0000001, 10'd0,  1'b0, 3'd1, 16'h0000, 16,   4080,   4080,   3}, // R3 tiny fraction, max int
    '{8'd23,  28'h0000607, 10'd0,  1'b1, 3'd1, 16'h0000, 70,   1640,   1640,   4}, // R4 3/7, int at minimum
    '{8'd24,  28'h007CE28, 10'd15, 1'b1, 3'd1, 16'h0000, 1000, 24999,  24999,  4}, // R4 999/1000
    '{8'd30,  28'h0000E07, 10'd0,  1'b1, 3'd1, 16'h0000, 14,   434,    434,    7}, // R7 num == mod legal
    '{8'd100, 28'h0000A0C, 10'd0,  1'b1, 3'd2, 16'h0000, 120,  12049,  12052,  5}, // R5 order 2, 5/12
    '{8'd200, 28'h0004A24, 10'd1,  1'b1, 3'd3, 16'h0000, 1000, 200369, 200372, 5}, // R5 order 3, 37/100
    '{8'd80,  28'h4000000, 10'd0,  1'b0, 3'd7, 16'h0000, 64,   5135,   5138,   5}, // R5 order 7 acts as 3
    '{8'd77,  28'h8000000, 10'd0,  1'b0, 3'd0, 16'h0000, 20,   1540,   1540,   6}, // R6 order 0
    '{8'd40,  28'h8000000, 10'd0,  1'b0, 3'd1, 16'h4000, 16,   652,    652,    9}, // R9 +dither lifts fraction
    '{8'd40,  28'hFFFFFFF, 10'd0,  1'b0, 3'd1, 16'h7FFF, 16,   655,    655,    9}, // R9 clamp at top
    '{8'd23,  28'h0000607, 10'd0,  1'b1, 3'd1, 16'h7FFF, 70,   1640,   1640,   9}  // R9 ignored in rational
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input int act, input int lo, input int hi, input string req);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic do_load(input vec_t v);
    @(negedge clk);
    int_in = v.ii; frac_in = v.fr; mod_hi_in = v.mh; rat_en = v.rat;
    order_in = v.ord; dither_in = v.di; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_sum(input vec_t v, input bit alt_dither, output int sum, output int bad);
    int lo_o, hi_o, o;
    case (v.ord)
      3'd0:    begin lo_o = 0;  hi_o = 0; end
      3'd1:    begin lo_o = 0;  hi_o = 1; end
      3'd2:    begin lo_o = -1; hi_o = 2; end
      default: begin lo_o = -3; hi_o = 4; end
    endcase
    sum = 0; bad = 0;
    for (int i = 0; i < v.len; i++) begin
      @(negedge clk);
      sum += int'(div_out);
      o = int'(div_out) - int'(v.ii);
      if (o < lo_o || o > hi_o) bad++;
      if (alt_dither) dither_in = (i % 2 == 0) ? -16'sh4000 : 16'sh4000;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int sum, bad;
    vec_t v;
    repeat (2) @(negedge clk);
    chk(div_out == 0, "R1", int'(div_out), 0);
    chk(err == 0, "R1", int'(err), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(div_out == 0, "R1", int'(div_out), 0);
    chk(err == 0, "R1", int'(err), 0);

    for (int n = 0; n < NV; n++) begin
      do_load(VEC[n]);
      chk(div_out == 0, "R2", int'(div_out), 0);
      chk(err == 0, "R7", int'(err), 0);
      run_sum(VEC[n], 1'b0, sum, bad);
      if (sum < VEC[n].lo || sum > VEC[n].hi) begin
        n_chk++; n_fail++;
        $display("FAIL R%0d: vector %0d sum actual %0d expected %0d..%0d",
                 VEC[n].req, n, sum, VEC[n].lo, VEC[n].hi);
      end else n_chk++;
      chk(bad == 0, "R10", bad, 0);
    end

    // R2: unloaded changes have no effect
    v = VEC[3];
    do_load(v);
    run_sum(v, 1'b0, sum, bad);
    int_in = 8'd99; frac_in = 28'h8000000; order_in = 3'd0; rat_en = 1'b0;
    run_sum(v, 1'b0, sum, bad);
    chk(sum == 1640, "R2", sum, 1640);

    // R9: alternating dither keeps the average
    v = '{8'd40, 28'h8000000, 10'd0, 1'b0, 3'd1, 16'h4000, 16, 648, 648, 9};
    do_load(v);
    run_sum(v, 1'b1, sum, bad);
    chk(sum == 648, "R9", sum, 648);
    dither_in = '0;

    // R7: numerator 8 over modulus 7
    v = '{8'd30, 28'h0001007, 10'd0, 1'b1, 3'd1, 16'h0000, 10, 0, 0, 7};
    do_load(v);
    chk(err == 1, "R7", int'(err), 1);
    run_sum(v, 1'b0, sum, bad);
    chk(sum == 0, "R7", sum, 0);
    chk(err == 1, "R7", int'(err), 1);

    // R7: same word with rational off is a legal binary fraction
    v = '{8'd30, 28'h0001007, 10'd0, 1'b0, 3'd1, 16'h0000, 4, 120, 120, 7};
    do_load(v);
    chk(err == 0, "R7", int'(err), 0);
    run_sum(v, 1'b0, sum, bad);
    chk(sum == 120, "R7", sum, 120);

    // R8: integer 22 rejected, then cleared by a legal load
    v = '{8'd22, 28'h0000000, 10'd0, 1'b0, 3'd0, 16'h0000, 5, 0, 0, 8};
    do_load(v);
    chk(err == 1, "R8", int'(err), 1);
    run_sum(v, 1'b0, sum, bad);
    chk(sum == 0, "R8", sum, 0);
    v.ii = 8'd23;
    do_load(v);
    chk(err == 0, "R8", int'(err), 0);
    run_sum(v, 1'b0, sum, bad);
    chk(sum == 115, "R8", sum, 115);

    // R1: reset in mid-run
    v = VEC[7];
    do_load(v);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(div_out == 0, "R1", int'(div_out), 0);
    chk(err == 0, "R1", int'(err), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(div_out == 0, "R1", int'(div_out), 0);

    finish_up();
  end
endmodule